// File: doc/BRIEF.md
# Three-Input Programmable ALU

This block is a purely combinational 32-bit arithmetic and logic unit with three operands. An 8-bit function code and a mode bit steer it. In logic mode the function code is a truth table over the three operand bits at each bit position, so any of the 256 three-input Boolean functions can be selected. In arithmetic mode the first operand, optionally masked by the third, is added to or reduced by a bitwise two-input function of the second and third operands. The carry-in adds one more or one less.

The adder can be split into independent 16-bit or 8-bit lanes, so several packed values are handled in one operation. Each lane can saturate on its own overflow, using either signed or unsigned limits. Carry and overflow flags report the most significant lane. A zero flag reports the final result. The block has no clock and no state. It is meant to sit between operand and result registers in a processor datapath.

Top module: `three_input_alu`

## Requirements
- R1: In logic mode (`arith_en`=0), every result bit i equals `func_code[4*opd_a[i] + 2*opd_b[i] + opd_c[i]]`.
- R2: In logic mode, `carry_flag` and `ovf_flag` are 0 for every function code.
- R3: In arithmetic mode, the operand Y at bit i is `func_code[2*opd_b[i] + opd_c[i]]`, so `func_code[3:0]` is a truth table over B and C. The operand X is selected by `func_code[7:6]`: 00 gives A, 01 gives A AND C, 10 gives A AND NOT C, and 11 gives zero.
- R4: `func_code[4]`=0 gives X+Y and `func_code[4]`=1 gives X-Y. When `func_code[5]`=1, an add gains one more and a subtract gives one less.
- R5: `lane_mode` 0 gives one 32-bit lane, 1 gives two 16-bit lanes, and 2 or 3 gives four 8-bit lanes. No carry passes from one lane to the next.
- R6: With `sat_en`=1 and `signed_en`=0, a lane whose unsigned add carries out becomes all ones. A lane whose unsigned subtract borrows becomes zero.
- R7: With `sat_en`=1 and `signed_en`=1, a lane with signed overflow becomes its signed maximum if X in that lane is non-negative, and its signed minimum otherwise.
- R8: `carry_flag` is the raw carry out of the top lane. `ovf_flag` is the top lane's signed overflow when `signed_en`=1. Otherwise it is the top lane's unsigned carry (add) or borrow (subtract). Both flags are reported whether saturation is on or off.
- R9: `zero_flag` is 1 exactly when the final result, after any saturation, is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 32 | Operand A |
| opd_b | input | 32 | Operand B |
| opd_c | input | 32 | Operand C (mask operand) |
| arith_en | input | 1 | 0 selects logic mode, 1 selects arithmetic mode |
| func_code | input | 8 | Truth table (logic) or operation fields (arithmetic) |
| lane_mode | input | 2 | Lane split: 0 gives 32 bits, 1 gives 16 bits, 2 or 3 gives 8 bits |
| sat_en | input | 1 | Per-lane saturation enable |
| signed_en | input | 1 | Signed limits and flags when 1, unsigned when 0 |
| result | output | 32 | ALU result |
| zero_flag | output | 1 | Result is all zeros |
| carry_flag | output | 1 | Carry out of the top lane |
| ovf_flag | output | 1 | Overflow of the top lane |

## Verification
The block holds no state, so any internal error shows on the ports in the same evaluation as the inputs that expose it, with no latency. Three kinds of fault are possible. A wrongly indexed truth table corrupts individual result bits for particular function codes. A carry that leaks across a lane boundary shifts the low bit of the next lane up. A lane flag taken from the wrong slice saturates the wrong byte or halfword. The bench therefore sweeps every logic code, drives packed values that straddle the lane boundaries, and compares random arithmetic vectors with an independent lane-by-lane model.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
   typedef enum logic [1:0] {
      LANE_FULL  = 2'd0,
      LANE_HALF  = 2'd1,
      LANE_BYTE  = 2'd2,
      LANE_BYTE2 = 2'd3
   } lane_mode_e;
endpackage

// File: rtl/tpa_logic_unit.sv
module tpa_logic_unit #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   input  logic [7:0]   tt,
   output logic [W-1:0] y
);
   // each bit looks up its own minterm in the 8-entry truth table
   always_comb begin
      for (int i = 0; i < W; i++) begin
         y[i] = tt[{a[i], b[i], c[i]}];
      end
   end
endmodule

// File: rtl/tpa_operand_prep.sv
module tpa_operand_prep #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   input  logic [7:0]   fc,
   output logic [W-1:0] x_opd,
   output logic [W-1:0] y_opd,
   output logic         is_sub,
   output logic         cin
);
   logic [W-1:0] f_bc;

   always_comb begin
      for (int i = 0; i < W; i++) begin
         f_bc[i] = fc[{b[i], c[i]}];
      end
      case (fc[7:6])
         2'b00:   x_opd = a;
         2'b01:   x_opd = a & c;
         2'b10:   x_opd = a & ~c;
         default: x_opd = '0;
      endcase
      is_sub = fc[4];
      // subtract is X + ~Y + 1; bit 5 moves the result by one either way
      cin    = fc[5] ^ fc[4];
      y_opd  = fc[4] ? ~f_bc : f_bc;
   end
endmodule

// File: rtl/tpa_lane_adder.sv
module tpa_lane_adder
   import tpa_pkg::*;
#(
   parameter int W     = 32,
   parameter int SLICE = 8
) (
   input  logic [W-1:0]       x,
   input  logic [W-1:0]       y,
   input  logic               cin,
   input  lane_mode_e         mode,
   output logic [W-1:0]       sum,
   output logic [W/SLICE-1:0] co,
   output logic [W/SLICE-1:0] sov,
   output logic [W/SLICE-1:0] top
);
   localparam int NS = W / SLICE;

   int             per;
   logic           carry;
   logic [SLICE:0] t;

   always_comb begin
      case (mode)
         LANE_FULL: per = NS;
         LANE_HALF: per = 2;
         default:   per = 1;
      endcase
      carry = cin;
      t     = '0;
      for (int k = 0; k < NS; k++) begin
         if ((k % per) == 0) carry = cin;
         t = {1'b0, x[k*SLICE +: SLICE]} + {1'b0, y[k*SLICE +: SLICE]}
             + {{SLICE{1'b0}}, carry};
         sum[k*SLICE +: SLICE] = t[SLICE-1:0];
         co[k]  = t[SLICE];
         sov[k] = (x[k*SLICE+SLICE-1] == y[k*SLICE+SLICE-1]) &&
                  (t[SLICE-1] != x[k*SLICE+SLICE-1]);
         top[k] = ((k % per) == (per - 1));
         carry  = t[SLICE];
      end
   end
endmodule

// File: rtl/tpa_saturate.sv
module tpa_saturate #(
   parameter int W     = 32,
   parameter int SLICE = 8
) (
   input  logic [W-1:0]       sum,
   input  logic [W-1:0]       x,
   input  logic [W/SLICE-1:0] co,
   input  logic [W/SLICE-1:0] sov,
   input  logic [W/SLICE-1:0] top,
   input  logic               is_sub,
   input  logic               sat_en,
   input  logic               sgn,
   output logic [W-1:0]       y,
   output logic               carry_top,
   output logic               ovf_top
);
   localparam int              NS   = W / SLICE;
   localparam logic [SLICE-1:0] MINS = {1'b1, {(SLICE-1){1'b0}}};
   localparam logic [SLICE-1:0] MAXS = ~MINS;

   logic l_uov, l_sov, l_neg, l_ov;

   // walk from the top slice down so every slice inherits its lane's flags
   always_comb begin
      l_uov = 1'b0;
      l_sov = 1'b0;
      l_neg = 1'b0;
      l_ov  = 1'b0;
      y     = sum;
      for (int k = NS - 1; k >= 0; k--) begin
         if (top[k]) begin
            l_uov = is_sub ? ~co[k] : co[k];
            l_sov = sov[k];
            l_neg = x[k*SLICE+SLICE-1];
         end
         l_ov = sgn ? l_sov : l_uov;
         if (sat_en && l_ov) begin
            if (sgn)
               y[k*SLICE +: SLICE] = l_neg ? (top[k] ? MINS : '0)
                                           : (top[k] ? MAXS : '1);
            else
               y[k*SLICE +: SLICE] = is_sub ? '0 : '1;
         end
      end
      carry_top = co[NS-1];
      ovf_top   = sgn ? sov[NS-1] : (is_sub ? ~co[NS-1] : co[NS-1]);
   end
endmodule

// File: rtl/three_input_alu.sv
module three_input_alu
   import tpa_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SLICE = 8
) (
   input  logic [WIDTH-1:0] opd_a,
   input  logic [WIDTH-1:0] opd_b,
   input  logic [WIDTH-1:0] opd_c,
   input  logic             arith_en,
   input  logic [7:0]       func_code,
   input  logic [1:0]       lane_mode,
   input  logic             sat_en,
   input  logic             signed_en,
   output logic [WIDTH-1:0] result,
   output logic             zero_flag,
   output logic             carry_flag,
   output logic             ovf_flag
);
   localparam int NS = WIDTH / SLICE;

   generate
      if (SLICE < 2 || (WIDTH % (2 * SLICE)) != 0) begin : g_bad_geometry
         $error("three_input_alu: WIDTH must be a multiple of 2*SLICE, SLICE >= 2");
      end
   endgenerate

   logic [WIDTH-1:0] logic_y, x_opd, y_opd, sum, arith_y;
   logic [NS-1:0]    co, sov, top;
   logic             is_sub, cin, carry_top, ovf_top;

   tpa_logic_unit #(.W(WIDTH)) u_logic (
      .a(opd_a), .b(opd_b), .c(opd_c), .tt(func_code), .y(logic_y)
   );

   tpa_operand_prep #(.W(WIDTH)) u_prep (
      .a(opd_a), .b(opd_b), .c(opd_c), .fc(func_code),
      .x_opd(x_opd), .y_opd(y_opd), .is_sub(is_sub), .cin(cin)
   );

   tpa_lane_adder #(.W(WIDTH), .SLICE(SLICE)) u_add (
      .x(x_opd), .y(y_opd), .cin(cin), .mode(lane_mode_e'(lane_mode)),
      .sum(sum), .co(co), .sov(sov), .top(top)
   );

   tpa_saturate #(.W(WIDTH), .SLICE(SLICE)) u_sat (
      .sum(sum), .x(x_opd), .co(co), .sov(sov), .top(top),
      .is_sub(is_sub), .sat_en(sat_en), .sgn(signed_en),
      .y(arith_y), .carry_top(carry_top), .ovf_top(ovf_top)
   );

   always_comb begin
      result     = arith_en ? arith_y : logic_y;
      carry_flag = arith_en & carry_top;
      ovf_flag   = arith_en & ovf_top;
      zero_flag  = (result == '0);
   end
endmodule

// File: rtl/tpa_checker.sv
module tpa_checker #(
   parameter int W     = 32,
   parameter int SLICE = 8
) (
   input logic [W-1:0] opd_a,
   input logic [W-1:0] opd_b,
   input logic [W-1:0] opd_c,
   input logic         arith_en,
   input logic [7:0]   func_code,
   input logic [1:0]   lane_mode,
   input logic         sat_en,
   input logic         signed_en,
   input logic [W-1:0] result,
   input logic         carry_flag,
   input logic         ovf_flag
);
   localparam int NS = W / SLICE;

   always_comb begin
      if (!arith_en && func_code == 8'hF0) begin
         // R1
         bool_pass_a_chk: assert (result == opd_a)
            else $error("logic code F0 must pass operand A");
      end
      if (!arith_en) begin
         // R2
         bool_flags_chk: assert (!carry_flag && !ovf_flag)
            else $error("flags must be clear in logic mode");
      end
      if (arith_en && func_code == 8'h48 && lane_mode == 2'd0 && !sat_en) begin
         // R3
         masked_add_chk: assert (result == ((opd_a & opd_c) + (opd_b & opd_c)))
            else $error("masked add mismatch");
      end
      if (arith_en && func_code == 8'h0C && lane_mode == 2'd2 && !sat_en) begin
         for (int k = 0; k < NS; k++) begin
            // R5
            lane_sum_chk: assert (result[k*SLICE +: SLICE] ==
                                  opd_a[k*SLICE +: SLICE] + opd_b[k*SLICE +: SLICE])
               else $error("byte lane sum mismatch");
         end
      end
      if (arith_en && func_code == 8'h0C && lane_mode == 2'd2 && sat_en && !signed_en) begin
         for (int k = 0; k < NS; k++) begin
            // R6
            no_wrap_chk: assert (result[k*SLICE +: SLICE] >= opd_a[k*SLICE +: SLICE])
               else $error("unsigned saturating byte add wrapped");
         end
      end
   end
endmodule

bind three_input_alu tpa_checker #(.W(WIDTH), .SLICE(SLICE)) u_chk (
   .opd_a(opd_a), .opd_b(opd_b), .opd_c(opd_c), .arith_en(arith_en),
   .func_code(func_code), .lane_mode(lane_mode), .sat_en(sat_en),
   .signed_en(signed_en), .result(result), .carry_flag(carry_flag),
   .ovf_flag(ovf_flag)
);

// File: tb/sim_three_input_alu.sv
module sim_three_input_alu;
   logic        clk = 1'b0;
   logic [31:0] opd_a, opd_b, opd_c, result;
   logic        arith_en, sat_en, signed_en, zero_flag, carry_flag, ovf_flag;
   logic [7:0]  func_code;
   logic [1:0]  lane_mode;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   three_input_alu u0 (
      .opd_a(opd_a), .opd_b(opd_b), .opd_c(opd_c), .arith_en(arith_en),
      .func_code(func_code), .lane_mode(lane_mode), .sat_en(sat_en),
      .signed_en(signed_en), .result(result), .zero_flag(zero_flag),
      .carry_flag(carry_flag), .ovf_flag(ovf_flag)
   );

   // tag, arith, fcode, lane, sat, sgn, a, b, c, y, carry, ovf, zero
   localparam logic [147:0] VEC [12] = '{
      {4'd1, 1'b0, 8'h96, 2'd0, 1'b0, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0,
       32'h0FF00FF0, 1'b0, 1'b0, 1'b0},
      {4'd8, 1'b1, 8'h0C, 2'd0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h0,
       32'h00000000, 1'b1, 1'b1, 1'b1},
      {4'd5, 1'b1, 8'h0C, 2'd2, 1'b0, 1'b0, 32'h01FF7F80, 32'h01010101, 32'h0,
       32'h02008081, 1'b0, 1'b0, 1'b0},
      {4'd6, 1'b1, 8'h0C, 2'd2, 1'b1, 1'b0, 32'h01FF7F80, 32'h01010101, 32'h0,
       32'h02FF8081, 1'b0, 1'b0, 1'b0},
      {4'd7, 1'b1, 8'h0C, 2'd2, 1'b1, 1'b1, 32'h01FF7F80, 32'h01010101, 32'h0,
       32'h02007F81, 1'b0, 1'b0, 1'b0},
      {4'd6, 1'b1, 8'h1C, 2'd1, 1'b1, 1'b0, 32'h00050003, 32'h00030005, 32'h0,
       32'h00020000, 1'b1, 1'b0, 1'b0},
      {4'd3, 1'b1, 8'h48, 2'd0, 1'b0, 1'b0, 32'h12345678, 32'h11111111, 32'hFFFF0000,
       32'h23450000, 1'b0, 1'b0, 1'b0},
      {4'd7, 1'b1, 8'h20, 2'd0, 1'b1, 1'b1, 32'h7FFFFFFF, 32'h0, 32'h0,
       32'h7FFFFFFF, 1'b0, 1'b1, 1'b0},
      {4'd4, 1'b1, 8'hDC, 2'd0, 1'b0, 1'b0, 32'h0, 32'h00000001, 32'h0,
       32'hFFFFFFFF, 1'b0, 1'b1, 1'b0},
      {4'd9, 1'b1, 8'h1C, 2'd2, 1'b1, 1'b0, 32'h01020304, 32'h05060708, 32'h0,
       32'h00000000, 1'b0, 1'b1, 1'b1},
      {4'd3, 1'b1, 8'h8C, 2'd0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h0000FFFF,
       32'hFFFF0001, 1'b0, 1'b0, 1'b0},
      {4'd4, 1'b1, 8'h3C, 2'd0, 1'b0, 1'b0, 32'h00000010, 32'h00000003, 32'h0,
       32'h0000000C, 1'b1, 1'b0, 1'b0}
   };

   function automatic string tag_name(input int t);
      case (t)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         default: return "R9";
      endcase
   endfunction

   // independent reference: returns {y, carry, ovf, zero}
   function automatic logic [34:0] ref_model(input bit ar, input bit [7:0] f,
                                             input bit [1:0] lm, input bit st,
                                             input bit sg, input bit [31:0] a,
                                             input bit [31:0] b, input bit [31:0] c);
      bit [31:0] y, xo, yo;
      bit        cy, ov, uov, sov, sub, cin;
      int        lw;
      longint    mask, xl, yl, full, sx, sy, sfull, res;
      y = '0; cy = 1'b0; ov = 1'b0;
      if (!ar) begin
         for (int i = 0; i < 32; i++) y[i] = f[{a[i], b[i], c[i]}];
         return {y, 1'b0, 1'b0, (y == 32'h0)};
      end
      for (int i = 0; i < 32; i++) yo[i] = f[{b[i], c[i]}];
      case (f[7:6])
         2'b00:   xo = a;
         2'b01:   xo = a & c;
         2'b10:   xo = a & ~c;
         default: xo = 32'h0;
      endcase
      sub  = f[4];
      cin  = f[5] ^ f[4];
      lw   = (lm == 2'd0) ? 32 : (lm == 2'd1) ? 16 : 8;
      mask = (longint'(1) << lw) - 1;
      for (int base = 0; base < 32; base += lw) begin
         xl    = (longint'(xo) >> base) & mask;
         yl    = (longint'(yo) >> base) & mask;
         full  = sub ? xl - yl - 1 + longint'(cin) : xl + yl + longint'(cin);
         uov   = sub ? (full < 0) : (full > mask);
         sx    = (xl > (mask >> 1)) ? xl - (mask + 1) : xl;
         sy    = (yl > (mask >> 1)) ? yl - (mask + 1) : yl;
         sfull = sub ? sx - sy - 1 + longint'(cin) : sx + sy + longint'(cin);
         sov   = (sfull > (mask >> 1)) || (sfull < -((mask + 1) >> 1));
         res   = full & mask;
         ov    = sg ? sov : uov;
         cy    = sub ? !(full < 0) : (full > mask);
         if (st && ov) res = sg ? ((sx < 0) ? ((mask + 1) >> 1) : (mask >> 1))
                                : (sub ? 0 : mask);
         for (int j = 0; j < lw; j++) y[base + j] = res[j];
      end
      return {y, cy, ov, (y == 32'h0)};
   endfunction

   task automatic apply_check(input string tag, input bit ar, input bit [7:0] f,
                              input bit [1:0] lm, input bit st, input bit sg,
                              input bit [31:0] a, input bit [31:0] b,
                              input bit [31:0] c, input logic [34:0] exp);
      @(negedge clk);
      {arith_en, func_code, lane_mode, sat_en, signed_en, opd_a, opd_b, opd_c} =
         {ar, f, lm, st, sg, a, b, c};
      @(posedge clk);
      #1;
      n_vec++;
      if ({result, carry_flag, ovf_flag, zero_flag} !== exp) begin
         n_fail++;
         $display("FAIL %s: got y=%h c=%b v=%b z=%b, expected y=%h c=%b v=%b z=%b",
                  tag, result, carry_flag, ovf_flag, zero_flag,
                  exp[34:3], exp[2], exp[1], exp[0]);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      {arith_en, func_code, lane_mode, sat_en, signed_en, opd_a, opd_b, opd_c} = '0;
      repeat (2) @(posedge clk);
      // R2 idle/reset-state inputs: logic code 00 gives zero, flags clear
      apply_check("R2", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0,
                  {32'h0, 1'b0, 1'b0, 1'b1});

      foreach (VEC[i]) begin
         apply_check(tag_name(int'(VEC[i][147:144])), VEC[i][143], VEC[i][142:135],
                     VEC[i][134:133], VEC[i][132], VEC[i][131], VEC[i][130:99],
                     VEC[i][98:67], VEC[i][66:35], VEC[i][34:0]);
      end

      // R1 every truth table code, two operand patterns
      for (int f = 0; f < 256; f++) begin
         apply_check("R1", 1'b0, f[7:0], 2'd0, 1'b0, 1'b0,
                     32'hF0F0F0F0, 32'hCCCCCCCC, 32'hAAAAAAAA,
                     ref_model(1'b0, f[7:0], 2'd0, 1'b0, 1'b0,
                               32'hF0F0F0F0, 32'hCCCCCCCC, 32'hAAAAAAAA));
         apply_check("R1", 1'b1 ^ 1'b1, f[7:0], 2'd1, 1'b1, 1'b1,
                     32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C,
                     ref_model(1'b0, f[7:0], 2'd1, 1'b1, 1'b1,
                               32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C));
      end

      // R2 all-ones logic result with arithmetic-looking inputs
      apply_check("R2", 1'b0, 8'hFF, 2'd2, 1'b1, 1'b1, 32'hFFFFFFFF, 32'h1, 32'h0,
                  {32'hFFFFFFFF, 1'b0, 1'b0, 1'b0});

      // R5 R6 R7 R8 random arithmetic against the lane model
      for (int n = 0; n < 600; n++) begin
         bit [7:0]  f;
         bit [1:0]  lm;
         bit        st, sg;
         bit [31:0] a, b, c;
         f  = 8'($urandom);
         lm = 2'($urandom);
         st = 1'($urandom);
         sg = 1'($urandom);
         a  = $urandom;
         b  = $urandom;
         c  = $urandom;
         apply_check("R5", 1'b1, f, lm, st, sg, a, b, c,
                     ref_model(1'b1, f, lm, st, sg, a, b, c));
      end

      // R9 signed saturation that lands on a non-zero min, zero flag low
      apply_check("R9", 1'b1, 8'h1C, 2'd1, 1'b1, 1'b1, 32'h80000000, 32'h00010000,
                  32'h0, {32'h80000000, 1'b1, 1'b1, 1'b0});

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule